// File: doc/BRIEF.md
# Cascaded Interrupt Vector Controller

Two 8-input priority interrupt controllers joined into one 16-line unit. The first controller (the master) serves request lines 0 to 7 and raises the processor interrupt. The second controller (the slave) serves request lines 8 to 15. The slave's own interrupt output takes the place of the master's level-2 input. A request on a slave line must therefore win two resolvers in a row: first the slave's, then the master's, where it competes as level 2.

Software sets up the block through a small port write bus. Each controller has a write-only vector-base register, and the master also has a cascade word that connects the slave to level 2. The processor answers the interrupt with two acknowledge pulses. The first pulse freezes the winning level and moves it into service. The second pulse puts the 8-bit vector on the data bus. An end-of-interrupt pulse to a controller releases its highest-priority level in service.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `intr` and `vec_oe` are low, the master vector base is 08h, the slave vector base is 70h, and the slave is not linked to level 2.
- R2: A write to port 21h (master) or A1h (slave) loads bits 7:3 of the data as that controller's vector base. Data bits 2:0 are ignored.
- R3: Writes to the master port alternate. The first write after reset is a vector base, the next one is the cascade word, then a base again, and so on. In the cascade word, bit 2 = 1 links the slave and bit 2 = 0 unlinks it. All other bits are ignored.
- R4: A request is latched only on a rising edge of its line. It stays pending until it is acknowledged, even if the line falls. A line held high does not request again after it has been serviced.
- R5: Within each controller, priority is fixed: input 0 is the highest and input 7 the lowest.
- R6: `intr` is high only when the master's best pending level outranks every level in service in the master. `intr` is low from the first acknowledge pulse until the second one.
- R7: The first acknowledge pulse moves the winning level from pending to in service, and `vec_oe` stays low during that pulse.
- R8: During the second acknowledge pulse, `vec_oe` is high and `vec` = {master base[7:3], level code}, where the level code is the binary index 0 to 7 of the master level.
- R9: When master level 2 wins while linked, the vector is {slave base[7:3], code} with code = line number − 8. Both the slave level and master level 2 go into service.
- R10: The master's own level-2 line `irq[2]` is ignored. While the slave is unlinked, slave requests never raise `intr`.
- R11: `eoi_m` and `eoi_s` each clear only the highest-priority in-service level of their own controller. A serviced slave level needs one of each before lower levels may interrupt again.
- R12: An acknowledge taken with no valid winner returns {master base[7:3], 111} and changes no pending or in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Port write strobe |
| wr_addr | input | 8 | Port address |
| wr_data | input | 8 | Port write data |
| irq | input | 16 | Request lines 0 to 15 |
| intr | output | 1 | Interrupt to processor |
| ack | input | 1 | Acknowledge pulse |
| eoi_m | input | 1 | End of interrupt to master |
| eoi_s | input | 1 | End of interrupt to slave |
| vec | output | 8 | Vector byte, zero when not driven |
| vec_oe | output | 1 | Vector valid during second acknowledge |

## Verification
The bench builds the block with its default parameters: ports 21h and A1h, reset bases 08h and 70h, and the link on level 2. It then rewrites both bases to other values, so that the base field and the level code are checked independently of the reset values. Keeping the link on level 2 lets the bench reach the double-resolver path. It also reaches nesting behind an in-service slave level and the two-step end-of-interrupt release.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter logic [7:0] MPORT     = 8'h21,
  parameter logic [7:0] SPORT     = 8'hA1,
  parameter logic [7:0] MBASE_RST = 8'h08,
  parameter logic [7:0] SBASE_RST = 8'h70,
  parameter int         LINK      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [15:0] irq,
  output logic        intr,
  input  logic        ack,
  input  logic        eoi_m,
  input  logic        eoi_s,
  output logic [7:0]  vec,
  output logic        vec_oe
);
  localparam logic [7:0] LMASK = 8'(1 << LINK);
  localparam logic [2:0] LCODE = 3'(LINK);

  function automatic logic [3:0] pick(input logic [7:0] r);
    pick = 4'b0;
    for (int i = 7; i >= 0; i--)
      if (r[i]) pick = {1'b1, 3'(i)};
  endfunction

  function automatic logic [7:0] onehot(input logic [2:0] i);
    onehot = 8'(1) << i;
  endfunction

  logic [4:0]  mbase, sbase;
  logic        casc_en, m_sel_cfg, phase;
  logic [15:0] irq_q;
  logic [7:0]  m_irr, s_irr, m_isr, s_isr, m_req, held;
  logic [3:0]  s_top, s_itop, m_top, m_itop;
  logic        s_int, m_go, take;
  logic [15:0] rise;

  assign rise   = irq & ~irq_q;
  assign s_top  = pick(s_irr);
  assign s_itop = pick(s_isr);
  assign s_int  = s_top[3] && (!s_itop[3] || s_top[2:0] < s_itop[2:0]);

  always_comb begin
    m_req       = m_irr;
    m_req[LINK] = s_int & casc_en;
  end

  assign m_top  = pick(m_req);
  assign m_itop = pick(m_isr);
  assign m_go   = m_top[3] && (!m_itop[3] || m_top[2:0] < m_itop[2:0]);
  assign intr   = m_go && !phase;
  assign take   = ack && !phase;
  assign vec_oe = ack && phase;
  assign vec    = vec_oe ? held : 8'h00;

  logic [7:0] m_clr, s_clr, m_set, s_set, m_eoi, s_eoi;

  always_comb begin
    m_clr = 8'h00; s_clr = 8'h00; m_set = 8'h00; s_set = 8'h00;
    if (take && m_go) begin
      m_set = onehot(m_top[2:0]);
      if (m_top[2:0] == LCODE) begin
        s_set = onehot(s_top[2:0]);
        s_clr = s_set;
      end else begin
        m_clr = m_set;
      end
    end
    m_eoi = (eoi_m && m_itop[3]) ? onehot(m_itop[2:0]) : 8'h00;
    s_eoi = (eoi_s && s_itop[3]) ? onehot(s_itop[2:0]) : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mbase     <= MBASE_RST[7:3];
      sbase     <= SBASE_RST[7:3];
      casc_en   <= 1'b0;
      m_sel_cfg <= 1'b0;
      phase     <= 1'b0;
      irq_q     <= 16'h0;
      m_irr     <= 8'h00;
      s_irr     <= 8'h00;
      m_isr     <= 8'h00;
      s_isr     <= 8'h00;
      held      <= 8'h00;
    end else begin
      irq_q <= irq;
      m_irr <= (m_irr & ~m_clr) | (rise[7:0] & ~LMASK);
      s_irr <= (s_irr & ~s_clr) | rise[15:8];
      m_isr <= (m_isr & ~m_eoi) | m_set;
      s_isr <= (s_isr & ~s_eoi) | s_set;
      if (ack) phase <= ~phase;
      if (take) begin
        if (!m_go)                    held <= {mbase, 3'b111};
        else if (m_top[2:0] == LCODE) held <= {sbase, s_top[2:0]};
        else                          held <= {mbase, m_top[2:0]};
      end
      if (wr_en && wr_addr == SPORT) sbase <= wr_data[7:3];
      if (wr_en && wr_addr == MPORT) begin
        if (m_sel_cfg) casc_en <= wr_data[LINK];
        else           mbase   <= wr_data[7:3];
        m_sel_cfg <= ~m_sel_cfg;
      end
    end
  end

  p_intr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !intr);
  p_isr_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_go) |=> (m_isr != 8'h00));
  p_slave_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && m_go && m_top[2:0] == LCODE) |=> (s_isr != 8'h00 && m_isr[LINK]));
  p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_isr[LINK]) |-> $past(casc_en));
  p_eoi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_m && !take) |=> ($past(m_isr) == 8'h00 || $countones(m_isr) < $countones($past(m_isr))));
endmodule

// File: tb/cascade_intc_bench.sv
module cascade_intc_bench;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, wr_en = 0, ack = 0, eoi_m = 0, eoi_s = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic [15:0] irq = 0;
  logic intr, vec_oe;
  logic [7:0] vec;
  int errors = 0, checks = 0;
  logic [7:0] q[$];
  string qtag[$];
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  cascade_intc u_cascade_intc (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq(irq), .intr(intr), .ack(ack), .eoi_m(eoi_m), .eoi_s(eoi_s),
    .vec(vec), .vec_oe(vec_oe));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (vec_oe) begin
      if (q.size() == 0) chk("R8 unexpected vector", vec, 8'hxx);
      else chk(qtag.pop_front(), vec, q.pop_front());
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_ack(input logic [7:0] exp, input string tag);
    q.push_back(exp); qtag.push_back(tag);
    @(negedge clk); ack = 1; #1; chk("R7 no vector on first ack", {7'd0, vec_oe}, 8'd0);
    @(negedge clk); ack = 0; chk("R6 intr low between acks", {7'd0, intr}, 8'd0);
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
  endtask

  task automatic pwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic eoi(input bit m, input bit s);
    @(negedge clk); eoi_m = m; eoi_s = s;
    @(negedge clk); eoi_m = 0; eoi_s = 0;
  endtask

  task automatic intr_is(input string tag, input bit exp);
    chk(tag, {7'd0, intr}, {7'd0, exp});
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3); rst_n = 1; step(1);
    intr_is("R1 intr after reset", 0);
    chk("R1 vec_oe after reset", {7'd0, vec_oe}, 8'd0);
    do_ack(8'h0F, "R12 spurious vector with default base (R1)");

    irq[5] = 1; step(1);
    intr_is("R4 rising edge latched", 1);
    do_ack(8'h0D, "R8 master level 5 vector");
    intr_is("R4 held line does not retrigger", 0);
    irq[5] = 0; eoi(1, 0);

    irq[3] = 1; irq[6] = 1; step(1); irq[3] = 0; irq[6] = 0;
    do_ack(8'h0B, "R5 level 3 beats level 6");
    step(1); intr_is("R6 pending 6 blocked by in-service 3", 0);
    eoi(1, 0); intr_is("R4 pending kept after line fell", 1);
    do_ack(8'h0E, "R5 level 6 served next");

    irq[1] = 1; step(1); irq[1] = 0;
    intr_is("R6 level 1 nests over in-service 6", 1);
    do_ack(8'h09, "R8 nested level 1");
    eoi(1, 0);
    irq[7] = 1; step(1); irq[7] = 0;
    intr_is("R11 eoi cleared only level 1, 6 still blocks 7", 0);
    eoi(1, 0); intr_is("R11 second eoi frees level 7", 1);
    do_ack(8'h0F, "R8 level 7");
    eoi(1, 0);

    irq[10] = 1; irq[2] = 1; step(1); irq[10] = 0; irq[2] = 0; step(1);
    intr_is("R10 unlinked slave and irq2 ignored", 0);

    pwrite(8'h21, 8'h47);
    pwrite(8'h21, 8'h04);
    intr_is("R3 cascade word links slave", 1);
    do_ack(8'h72, "R9 slave line 10 vector");
    irq[13] = 1; step(1); irq[13] = 0;
    intr_is("R11 slave 13 blocked by in-service 10", 0);
    eoi(0, 1); intr_is("R11 master level 2 still in service", 0);
    eoi(1, 0); intr_is("R11 both eois release", 1);
    do_ack(8'h75, "R9 slave line 13 vector");
    eoi(1, 1);

    pwrite(8'hA1, 8'h8D);
    irq[0] = 1; irq[9] = 1; step(1); irq[0] = 0; irq[9] = 0;
    do_ack(8'h40, "R2 master base 40h low bits ignored, level 0");
    eoi(1, 0);
    do_ack(8'h89, "R2 slave base 88h, line 9");
    eoi(1, 1);

    pwrite(8'h21, 8'h20);
    irq[4] = 1; step(1); irq[4] = 0;
    do_ack(8'h24, "R3 third master write is a base");
    eoi(1, 0);
    pwrite(8'h21, 8'h00);
    irq[8] = 1; step(2); irq[8] = 0;
    intr_is("R3 bit2 clear unlinks slave", 0);

    step(2);
    chk("R8 all expected vectors seen", 8'(q.size()), 8'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule